// File: doc/BRIEF.md
# Dual-Tone Period-Counting Frequency Detector

This block sits behind the band-split filters and limiting comparators of a keypad-tone receiver. It takes two hard-limited square waves, one from the low (row) band and one from the high (column) band. It names the keypad frequency each one carries by counting system-clock cycles between consecutive rising edges. Each measured period is compared against a window of cycle counts around each of the four frequencies of its band. The window edge lies halfway between a guaranteed-accept tolerance and a guaranteed-reject tolerance, and both tolerances are parameters.

A band is declared valid only after two back-to-back periods land in the same window. The detector raises a signal-condition flag while both bands are valid together, and it drops the flag as soon as either band loses validity. The row and column indices are captured whenever a valid pair is present, and they hold their last value otherwise. Later logic uses the flag to apply the tone-duration and pause guard times, which are not part of this block. An inhibit input removes the highest column frequency from recognition. A power-down input clears all detection state and holds the outputs.

Top module: `dual_tone_detector`

## Requirements
- R1: After a synchronous reset, the outputs read sig_o = 0, row_o = 0 and col_o = 0.
- R2: Row index encoding is 0 = 697 Hz, 1 = 770 Hz, 2 = 852 Hz, 3 = 941 Hz. Column index encoding is 0 = 1209 Hz, 1 = 1336 Hz, 2 = 1477 Hz, 3 = 1633 Hz. Any of the 16 nominal pairs sets sig_o = 1 and shows the row and column indices of that pair.
- R3: A tone that is off its nominal frequency by no more than 1.5 % plus 2 Hz, in either direction, is still accepted as that frequency.
- R4: A tone that is 3.5 % or more away from every nominal frequency of its band is not accepted, and sig_o stays 0.
- R5: sig_o is 1 only while both bands are valid. When only one band carries a valid tone, sig_o is 0. When a band starts carrying a non-keypad frequency, sig_o falls within a few clock cycles of the first rising edge that ends a mismatching period.
- R6: While inh_i is 1, a 1633 Hz column is never accepted. If inh_i rises while a 1633 Hz pair is being flagged, sig_o falls within a few cycles. The other three columns are not affected.
- R7: While pd_i is 1, sig_o is 0 and row_o and col_o hold their values. Tones applied during power-down are not detected. After pd_i falls, detection starts again from scratch.
- R8: A band is valid only after two consecutive complete periods fall in the same window. After both inputs start toggling from rest, sig_o stays 0 until the third rising edge of the slower input.
- R9: If a band sees no rising edge for twice the longest accepted period of its lowest frequency, that band becomes invalid and sig_o falls. Before that point the last valid classification is held.
- R10: row_o and col_o change only in cycles where a valid pair is present. When sig_o falls, they keep the last pair that was flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, counted to measure periods |
| rst | input | 1 | Synchronous active-high reset |
| pd_i | input | 1 | Power-down: clears detection state and forces the flag low |
| inh_i | input | 1 | Inhibit: excludes the 1633 Hz column from recognition |
| lo_sq_i | input | 1 | Limited square wave from the low (row) band, asynchronous |
| hi_sq_i | input | 1 | Limited square wave from the high (column) band, asynchronous |
| sig_o | output | 1 | Signal condition: a valid row and column pair is present |
| row_o | output | 2 | Index of the detected row frequency |
| col_o | output | 2 | Index of the detected column frequency |

## Verification
The hardest case to reach from the ports is the boundary between acceptance and rejection. Periods that are a few clock cycles inside or outside a window come only from carefully chosen half-period counts. The bench therefore computes, independently of the design, half-periods for tones at the required accept deviation and just beyond the reject deviation, on both sides of the band. The other hard case is the order of events around the two-period rule and the timeout. For these, the bench starts tones from rest or freezes an input and samples at points placed a safe fraction of a period away from the rising edges that decide the result.

// File: rtl/dtd_pkg.sv
package dtd_pkg;

  typedef logic [1:0] tone_idx_t;

  localparam int unsigned N_TONES = 4;

  // Nominal frequency of tone i of the selected band, ascending order.
  function automatic int unsigned band_hz(input bit high, input int unsigned i);
    int unsigned f;
    if (!high) begin
      case (i)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (i)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Shortest period in clock cycles accepted for frequency f (rounded up).
  function automatic longint unsigned per_min(input longint unsigned clk_hz,
                                              input longint unsigned f,
                                              input longint unsigned edge_ppm);
    longint unsigned den;
    den = f * (64'd1000000 + edge_ppm);
    return (clk_hz * 64'd1000000 + den - 64'd1) / den;
  endfunction

  // Longest period in clock cycles accepted for frequency f (rounded down).
  function automatic longint unsigned per_max(input longint unsigned clk_hz,
                                              input longint unsigned f,
                                              input longint unsigned edge_ppm);
    longint unsigned den;
    den = f * (64'd1000000 - edge_ppm);
    return (clk_hz * 64'd1000000) / den;
  endfunction

endpackage

// File: rtl/dtd_edge_sync.sv
module dtd_edge_sync (
  input  logic clk,
  input  logic clr,
  input  logic sq_i,
  output logic rise_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk) begin
    if (clr) s_q <= '0;
    else     s_q <= {s_q[1:0], sq_i};
  end

  // s_q[0..1] resolve metastability, s_q[2] is the previous settled level.
  assign rise_o = s_q[1] & ~s_q[2];
endmodule

// File: rtl/dtd_period_meter.sv
module dtd_period_meter #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned TMO   = 3000
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             rise_i,
  output logic [CNT_W-1:0] per_o,
  output logic             stb_o,
  output logic             tmo_o
);
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TMO);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      per_o   <= '0;
      stb_o   <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      tmo_o <= 1'b0;
      if (rise_i) begin
        if (armed_q) begin
          per_o <= cnt_q;
          stb_o <= 1'b1;
        end
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q >= TMO_C) begin
          armed_q <= 1'b0;
          tmo_o   <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= TMO_C);

  a_r9_tmo_disarms: assert property (@(posedge clk) disable iff (clr)
    (tmo_o && !rise_i) |-> !stb_o);
endmodule

// File: rtl/dtd_band_classifier.sv
module dtd_band_classifier
  import dtd_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 3579545,
  parameter int unsigned EDGE_PPM = 27500,
  parameter bit          HIGH     = 1'b0,
  parameter int unsigned CNT_W    = 14
) (
  input  logic                clk,
  input  logic                clr,
  input  logic [N_TONES-1:0]  mask_i,
  input  logic [CNT_W-1:0]    per_i,
  input  logic                stb_i,
  input  logic                tmo_i,
  output logic                vld_o,
  output tone_idx_t           idx_o
);
  logic [N_TONES-1:0] hit;
  tone_idx_t          hit_idx;
  logic               any_hit;
  logic               cand_ok_q;
  tone_idx_t          cand_idx_q;

  for (genvar i = 0; i < N_TONES; i++) begin : g_win
    localparam logic [CNT_W-1:0] LO_B =
      CNT_W'(per_min(64'(CLK_HZ), 64'(band_hz(HIGH, i)), 64'(EDGE_PPM)));
    localparam logic [CNT_W-1:0] HI_B =
      CNT_W'(per_max(64'(CLK_HZ), 64'(band_hz(HIGH, i)), 64'(EDGE_PPM)));
    assign hit[i] = !mask_i[i] && (per_i >= LO_B) && (per_i <= HI_B);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N_TONES; i++) begin
      if (hit[i]) hit_idx = tone_idx_t'(i);
    end
  end
  assign any_hit = |hit;

  always_ff @(posedge clk) begin
    if (clr) begin
      vld_o      <= 1'b0;
      idx_o      <= '0;
      cand_ok_q  <= 1'b0;
      cand_idx_q <= '0;
    end else if (tmo_i) begin
      vld_o     <= 1'b0;
      cand_ok_q <= 1'b0;
    end else if (stb_i) begin
      if (any_hit) begin
        cand_ok_q  <= 1'b1;
        cand_idx_q <= hit_idx;
        if (cand_ok_q && cand_idx_q == hit_idx) begin
          vld_o <= 1'b1;
          idx_o <= hit_idx;
        end else begin
          vld_o <= 1'b0;
        end
      end else begin
        vld_o     <= 1'b0;
        cand_ok_q <= 1'b0;
      end
    end else if (vld_o && mask_i[idx_o]) begin
      vld_o     <= 1'b0;
      cand_ok_q <= 1'b0;
    end
  end

  a_r8_rise_on_period: assert property (@(posedge clk) disable iff (clr)
    $rose(vld_o) |-> $past(stb_i));

  a_r9_tmo_clears: assert property (@(posedge clk) disable iff (clr)
    tmo_i |=> !vld_o);

  a_r6_mask_clears: assert property (@(posedge clk) disable iff (clr)
    (vld_o && mask_i[idx_o]) |=> !vld_o);

  a_r2_one_window: assert property (@(posedge clk) disable iff (clr)
    $onehot0(hit));
endmodule

// File: rtl/dual_tone_detector.sv
module dual_tone_detector
  import dtd_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned ACC_PPM = 20000,
  parameter int unsigned REJ_PPM = 35000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_i,
  input  logic       inh_i,
  input  logic       lo_sq_i,
  input  logic       hi_sq_i,
  output logic       sig_o,
  output logic [1:0] row_o,
  output logic [1:0] col_o
);
  localparam int unsigned EDGE_PPM = (ACC_PPM + REJ_PPM) / 2;
  localparam int unsigned LO_TMO =
    2 * int'(per_max(64'(CLK_HZ), 64'(band_hz(1'b0, 0)), 64'(EDGE_PPM)));
  localparam int unsigned HI_TMO =
    2 * int'(per_max(64'(CLK_HZ), 64'(band_hz(1'b1, 0)), 64'(EDGE_PPM)));
  localparam int unsigned CNT_W = $clog2(LO_TMO + 1);

  logic clr;
  assign clr = rst | pd_i;

  logic [1:0]       rise;
  logic [1:0]       stb;
  logic [1:0]       tmo;
  logic [1:0]       vld;
  tone_idx_t        idx   [2];
  logic [CNT_W-1:0] per   [2];
  logic [N_TONES-1:0] mask [2];
  logic [1:0]       sq;

  assign sq      = {hi_sq_i, lo_sq_i};
  assign mask[0] = '0;
  assign mask[1] = {inh_i, {(N_TONES-1){1'b0}}};

  for (genvar b = 0; b < 2; b++) begin : g_band
    localparam int unsigned TMO_B = (b == 0) ? LO_TMO : HI_TMO;

    dtd_edge_sync u_sync (
      .clk    (clk),
      .clr    (clr),
      .sq_i   (sq[b]),
      .rise_o (rise[b])
    );

    dtd_period_meter #(.CNT_W(CNT_W), .TMO(TMO_B)) u_meter (
      .clk    (clk),
      .clr    (clr),
      .rise_i (rise[b]),
      .per_o  (per[b]),
      .stb_o  (stb[b]),
      .tmo_o  (tmo[b])
    );

    dtd_band_classifier #(
      .CLK_HZ   (CLK_HZ),
      .EDGE_PPM (EDGE_PPM),
      .HIGH     (b == 1),
      .CNT_W    (CNT_W)
    ) u_class (
      .clk    (clk),
      .clr    (clr),
      .mask_i (mask[b]),
      .per_i  (per[b]),
      .stb_i  (stb[b]),
      .tmo_i  (tmo[b]),
      .vld_o  (vld[b]),
      .idx_o  (idx[b])
    );
  end

  logic pair_ok;
  assign pair_ok = !pd_i && vld[0] && vld[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_o <= 1'b0;
      row_o <= '0;
      col_o <= '0;
    end else begin
      sig_o <= pair_ok;
      if (pair_ok) begin
        row_o <= idx[0];
        col_o <= idx[1];
      end
    end
  end

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    pd_i |=> !sig_o);

  a_r5_needs_both: assert property (@(posedge clk) disable iff (rst)
    !(vld[0] && vld[1]) |=> !sig_o);

  a_r10_idx_hold: assert property (@(posedge clk) disable iff (rst)
    !(vld[0] && vld[1]) |=> ($stable(row_o) && $stable(col_o)));

  a_r6_inh_col: assert property (@(posedge clk) disable iff (rst)
    ($past(inh_i) && $past(inh_i, 2)) |-> !(sig_o && col_o == 2'd3));

  initial begin
    a_r4_tol_order: assert (ACC_PPM < REJ_PPM);
  end
endmodule

// File: tb/sim_dual_tone_detector.sv
module sim_dual_tone_detector;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1000000;
  localparam int SETTLE     = 4600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_i = 1'b0;
  logic inh_i = 1'b0;
  logic lo_sq_i = 1'b0;
  logic hi_sq_i = 1'b0;
  logic sig_o;
  logic [1:0] row_o, col_o;

  int n_chk = 0;
  int n_fail = 0;
  int lo_half = 0, hi_half = 0;
  int lo_cnt = 0, hi_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tone_detector #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .pd_i(pd_i), .inh_i(inh_i),
    .lo_sq_i(lo_sq_i), .hi_sq_i(hi_sq_i),
    .sig_o(sig_o), .row_o(row_o), .col_o(col_o)
  );

  // Square-wave generators, toggling every *_half cycles (0 = held low).
  always @(negedge clk) begin
    if (lo_half == 0) begin lo_sq_i <= 1'b0; lo_cnt <= 0; end
    else if (lo_cnt + 1 >= lo_half) begin lo_sq_i <= ~lo_sq_i; lo_cnt <= 0; end
    else lo_cnt <= lo_cnt + 1;
    if (hi_half == 0) begin hi_sq_i <= 1'b0; hi_cnt <= 0; end
    else if (hi_cnt + 1 >= hi_half) begin hi_sq_i <= ~hi_sq_i; hi_cnt <= 0; end
    else hi_cnt <= hi_cnt + 1;
  end

  function automatic int half_of(real f);
    return $rtoi(CLK_HZ / (2.0 * f) + 0.5);
  endfunction

  function automatic real lo_f(int i);
    real t [4] = '{697.0, 770.0, 852.0, 941.0};
    return t[i];
  endfunction

  function automatic real hi_f(int i);
    real t [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
    return t[i];
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_tones(real flo, real fhi);
    @(posedge clk);
    lo_half = (flo > 0.0) ? half_of(flo) : 0;
    hi_half = (fhi > 0.0) ? half_of(fhi) : 0;
  endtask

  task automatic chk(string req, logic es, logic [1:0] er, logic [1:0] ec, bit cmp_idx);
    n_chk++;
    if (sig_o !== es || (cmp_idx && (row_o !== er || col_o !== ec))) begin
      n_fail++;
      $display("FAIL %s: sig=%0b row=%0d col=%0d, expected sig=%0b row=%0d col=%0d",
               req, sig_o, row_o, col_o, es, er, ec);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", 1'b0, 2'd0, 2'd0, 1'b1);
  endtask

  task automatic t_startup();
    // R8: slower band 941 Hz, period ~1062; third rise ~2655 cycles in.
    set_tones(941.0, 1209.0);
    wait_cyc(2100);
    chk("R8", 1'b0, 2'd0, 2'd0, 1'b1);
    wait_cyc(650);
    chk("R8", 1'b1, 2'd3, 2'd0, 1'b1);
  endtask

  task automatic t_all_pairs();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        set_tones(lo_f(r), hi_f(c));
        wait_cyc(SETTLE);
        chk("R2", 1'b1, 2'(r), 2'(c), 1'b1);
      end
    end
  endtask

  task automatic t_accept_dev();
    set_tones(697.0 * 1.015 + 2.0, 1633.0 * 0.985 - 2.0);
    wait_cyc(SETTLE);
    chk("R3", 1'b1, 2'd0, 2'd3, 1'b1);
    set_tones(941.0 * 0.985 - 2.0, 1209.0 * 1.015 + 2.0);
    wait_cyc(SETTLE);
    chk("R3", 1'b1, 2'd3, 2'd0, 1'b1);
  endtask

  task automatic t_reject_dev();
    set_tones(770.0 * 1.036, 1336.0);
    wait_cyc(SETTLE);
    chk("R4", 1'b0, 2'd0, 2'd0, 1'b0);
    set_tones(852.0, 1477.0 * 0.964);
    wait_cyc(SETTLE);
    chk("R4", 1'b0, 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_drop();
    set_tones(770.0, 1477.0);
    wait_cyc(SETTLE);
    chk("R5", 1'b1, 2'd1, 2'd2, 1'b1);
    set_tones(770.0, 1100.0);
    wait_cyc(2700);
    chk("R5", 1'b0, 2'd0, 2'd0, 1'b0);
    chk("R10", 1'b0, 2'd1, 2'd2, 1'b1);
    set_tones(852.0, 0.0);
    wait_cyc(SETTLE);
    chk("R5", 1'b0, 2'd1, 2'd2, 1'b1);
  endtask

  task automatic t_timeout();
    set_tones(697.0, 1209.0);
    wait_cyc(SETTLE);
    chk("R9", 1'b1, 2'd0, 2'd0, 1'b1);
    set_tones(0.0, 1209.0);
    wait_cyc(1000);
    chk("R9", 1'b1, 2'd0, 2'd0, 1'b1);
    wait_cyc(2300);
    chk("R9", 1'b0, 2'd0, 2'd0, 1'b1);
  endtask

  task automatic t_inhibit();
    @(posedge clk); inh_i = 1'b1;
    set_tones(852.0, 1633.0);
    wait_cyc(SETTLE);
    chk("R6", 1'b0, 2'd0, 2'd0, 1'b0);
    set_tones(852.0, 1477.0);
    wait_cyc(SETTLE);
    chk("R6", 1'b1, 2'd2, 2'd2, 1'b1);
    @(posedge clk); inh_i = 1'b0;
    set_tones(941.0, 1633.0);
    wait_cyc(SETTLE);
    chk("R6", 1'b1, 2'd3, 2'd3, 1'b1);
    @(posedge clk); inh_i = 1'b1;
    wait_cyc(10);
    chk("R6", 1'b0, 2'd3, 2'd3, 1'b1);
    @(posedge clk); inh_i = 1'b0;
  endtask

  task automatic t_powerdown();
    set_tones(697.0, 1336.0);
    wait_cyc(SETTLE);
    chk("R7", 1'b1, 2'd0, 2'd1, 1'b1);
    @(posedge clk); pd_i = 1'b1;
    wait_cyc(10);
    chk("R7", 1'b0, 2'd0, 2'd1, 1'b1);
    set_tones(941.0, 1209.0);
    wait_cyc(SETTLE);
    chk("R7", 1'b0, 2'd0, 2'd1, 1'b1);
    @(posedge clk); pd_i = 1'b0;
    wait_cyc(SETTLE);
    chk("R7", 1'b1, 2'd3, 2'd0, 1'b1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_startup();
    t_all_pairs();
    t_accept_dev();
    t_reject_dev();
    t_drop();
    t_timeout();
    t_inhibit();
    t_powerdown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule